// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Software-Narrowed Tag Check

This block is a direct-mapped data cache for an embedded processor. Software can shrink the tag check at run time. A tag-enable mask holds one bit per tag column. Only the enabled columns are written into the tag store, read back and compared; the other columns are never driven. When a program loop's working set sits in a memory window whose addresses differ only in the low k tag bits, software enables just those k bits. If the set fits the cache outright, it enables none of them, and the cache then decides a hit from the line's valid bit alone.

Cold misses must still be caught when the tag check is narrowed or off. Software therefore starts a bulk invalidate before entering such a loop. The invalidate sweeps the valid bits clear, one line per cycle, and the cache reports busy while the sweep runs. Valid bits stay checked on every access, so a line touched for the first time on any iteration is fetched. Load misses refill a whole line over a simple request/acknowledge memory port. Stores write through on a separate one-cycle write strobe and update the cached word only on a hit.

Top module: `narrow_tag_dcache`

## Requirements
- R1: An address is split, from the bottom, into 2 byte bits (ignored), 2 word-select bits [3:2], a 6-bit line index [9:4] and a 6-bit tag [15:10]. A load hit returns the selected 32-bit word of the indexed line.
- R2: After reset the tag-enable mask is all ones and every line is invalid, so the first load to any line misses.
- R3: With all tag bits enabled, two addresses with the same index but different tags evict each other, and each access after the other one misses.
- R4: With only some low tag bits enabled, an address that differs from the cached line only in disabled tag bits hits and returns the cached word. An address that differs in an enabled bit misses.
- R5: With the mask all zero, a valid line hits whatever its tag, the tag store is not read, and no memory request is made.
- R6: A pulse on inv_start while idle holds busy high for exactly 64 cycles, beginning on the next cycle. No memory request is made during the sweep. Afterwards every line is invalid, even in zero-tag mode.
- R7: In zero-tag mode, a line never loaded since the invalidate misses once and then hits for any tag.
- R8: A load miss raises mem_req with mem_addr equal to address bits [15:4], and holds both until mem_ack. The acknowledged line is stored, and the load returns word [3:2] of mem_rdata (word w at bits 32w+31:32w).
- R9: Every store pulses mem_wr with its address and data. A store hit also updates the cached word. A store miss does not allocate, so a later load to that address misses.
- R10: A mask write in the same cycle a request is accepted does not affect that access; it applies from the next access on.
- R11: cpu_done is a one-cycle pulse. For a hit or a store it comes one edge after the request edge. For a load miss it comes on the edge that samples mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Access request, accepted when busy is low |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 16 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_done | output | 1 | One-cycle completion pulse |
| cpu_hit | output | 1 | Access hit, valid with cpu_done |
| cpu_rdata | output | 32 | Load data, valid with cpu_done |
| tag_en_wr | input | 1 | Write strobe for the tag-enable mask |
| tag_en_din | input | 6 | New tag-enable mask, one bit per tag column |
| inv_start | input | 1 | Start a bulk invalidate |
| busy | output | 1 | Access or sweep in progress |
| mem_req | output | 1 | Line refill request |
| mem_addr | output | 12 | Line address of the refill |
| mem_ack | input | 1 | Refill data present |
| mem_rdata | input | 128 | Refill line, word 0 in the low bits |
| mem_wr | output | 1 | Write-through strobe |
| mem_waddr | output | 16 | Write-through byte address |
| mem_wdata | output | 32 | Write-through data |

## Verification
A request is sampled on one rising edge. A hit or a store completes one edge later. A load miss shows mem_req one edge after the request edge, and completes on the edge that samples mem_ack; the bench raises mem_ack one cycle after it sees mem_req, so a miss completes on the third edge. The bench applies all inputs on the falling edge. It reads the outputs 1 ns after each rising edge and counts edges from the request, so each check confirms both the value and the latency. The sweep length is checked by counting busy cycles after the inv_start edge, and the late mask write is applied on the very edge that accepts a request.

// File: rtl/ntc_pkg.sv
package ntc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOOK  = 2'd1,
    ST_FILL  = 2'd2,
    ST_SWEEP = 2'd3
  } ntc_state_e;
endpackage

// File: rtl/ntc_ram.sv
// Simple dual-port synchronous RAM with a registered read, shaped for block RAM.
module ntc_ram #(
  parameter int W     = 32,
  parameter int DEPTH = 64,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/ntc_tag_match.sv
// Hit decision: the valid bit plus equality on the enabled tag columns only.
module ntc_tag_match #(
  parameter int TAG_W = 6
) (
  input  logic             line_valid,
  input  logic [TAG_W-1:0] stored_tag,
  input  logic [TAG_W-1:0] probe_tag,
  input  logic [TAG_W-1:0] col_en,
  output logic             hit
);
  logic [TAG_W-1:0] diff;

  always_comb begin
    diff = (stored_tag ^ probe_tag) & col_en;
    hit  = line_valid && (diff == '0);
  end
endmodule

// File: rtl/ntc_sweep.sv
// Walks every line index once, one per cycle, after a start pulse.
module ntc_sweep #(
  parameter int NUM_LINES = 64,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  output logic             active,
  output logic [IDX_W-1:0] idx,
  output logic             last
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_LINES - 1);

  assign last = active && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      idx    <= '0;
    end else if (start) begin
      active <= 1'b1;
      idx    <= '0;
    end else if (active) begin
      if (last) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/narrow_tag_dcache.sv
module narrow_tag_dcache
  import ntc_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int WORD_W      = 32,
  parameter int LINE_WORDS  = 4,
  parameter int NUM_LINES   = 64,
  parameter int BOFF_W      = $clog2(WORD_W / 8),
  parameter int WSEL_W      = $clog2(LINE_WORDS),
  parameter int IDX_W       = $clog2(NUM_LINES),
  parameter int TAG_W       = ADDR_W - BOFF_W - WSEL_W - IDX_W,
  parameter int LINE_ADDR_W = TAG_W + IDX_W
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cpu_req,
  input  logic                         cpu_we,
  input  logic [ADDR_W-1:0]            cpu_addr,
  input  logic [WORD_W-1:0]            cpu_wdata,
  output logic                         cpu_done,
  output logic                         cpu_hit,
  output logic [WORD_W-1:0]            cpu_rdata,
  input  logic                         tag_en_wr,
  input  logic [TAG_W-1:0]             tag_en_din,
  input  logic                         inv_start,
  output logic                         busy,
  output logic                         mem_req,
  output logic [LINE_ADDR_W-1:0]       mem_addr,
  input  logic                         mem_ack,
  input  logic [LINE_WORDS*WORD_W-1:0] mem_rdata,
  output logic                         mem_wr,
  output logic [ADDR_W-1:0]            mem_waddr,
  output logic [WORD_W-1:0]            mem_wdata
);
  localparam int WSEL_LSB = BOFF_W;
  localparam int IDX_LSB  = BOFF_W + WSEL_W;
  localparam int TAG_LSB  = IDX_LSB + IDX_W;

  ntc_state_e st;

  logic [TAG_W-1:0]  tag_en_q;
  logic [ADDR_W-1:0] acc_addr;
  logic              acc_we;
  logic [WORD_W-1:0] acc_wdata;
  logic [TAG_W-1:0]  acc_en;

  logic [NUM_LINES-1:0] valid_q;

  logic [IDX_W-1:0]  req_idx;
  logic [IDX_W-1:0]  acc_idx;
  logic [WSEL_W-1:0] acc_wsel;
  logic [TAG_W-1:0]  acc_tag;

  logic accept, sweep_start, in_look, look_hit, store_hit, fill_commit;
  logic tag_re, tag_we;
  logic [TAG_W-1:0] tag_q;

  logic              sweep_active, sweep_last;
  logic [IDX_W-1:0]  sweep_idx;

  logic [WORD_W-1:0] bank_rd [LINE_WORDS];
  logic [WORD_W-1:0] look_word;
  logic [WORD_W-1:0] fill_word;

  assign req_idx  = cpu_addr[IDX_LSB +: IDX_W];
  assign acc_idx  = acc_addr[IDX_LSB +: IDX_W];
  assign acc_wsel = acc_addr[WSEL_LSB +: WSEL_W];
  assign acc_tag  = acc_addr[TAG_LSB +: TAG_W];

  assign busy        = (st != ST_IDLE);
  assign sweep_start = (st == ST_IDLE) && inv_start;
  assign accept      = (st == ST_IDLE) && !inv_start && cpu_req;
  assign in_look     = (st == ST_LOOK);
  assign store_hit   = in_look && look_hit && acc_we;
  assign fill_commit = (st == ST_FILL) && mem_ack;

  // Tag columns are touched only when at least one is enabled.
  assign tag_re = accept && (|tag_en_q);
  assign tag_we = fill_commit && (|acc_en);

  ntc_ram #(.W(TAG_W), .DEPTH(NUM_LINES), .AW(IDX_W)) u_tag_ram (
    .clk   (clk),
    .re    (tag_re),
    .raddr (req_idx),
    .rdata (tag_q),
    .we    (tag_we),
    .waddr (acc_idx),
    .wdata (acc_tag & acc_en)
  );

  ntc_tag_match #(.TAG_W(TAG_W)) u_match (
    .line_valid (valid_q[acc_idx]),
    .stored_tag (tag_q),
    .probe_tag  (acc_tag),
    .col_en     (acc_en),
    .hit        (look_hit)
  );

  for (genvar g = 0; g < LINE_WORDS; g++) begin : g_bank
    logic              b_we;
    logic [WORD_W-1:0] b_wd;
    assign b_we = fill_commit || (store_hit && (acc_wsel == WSEL_W'(g)));
    assign b_wd = fill_commit ? mem_rdata[g*WORD_W +: WORD_W] : acc_wdata;

    ntc_ram #(.W(WORD_W), .DEPTH(NUM_LINES), .AW(IDX_W)) u_bank (
      .clk   (clk),
      .re    (accept),
      .raddr (req_idx),
      .rdata (bank_rd[g]),
      .we    (b_we),
      .waddr (acc_idx),
      .wdata (b_wd)
    );
  end

  always_comb begin
    look_word = bank_rd[acc_wsel];
    fill_word = mem_rdata[acc_wsel*WORD_W +: WORD_W];
  end

  ntc_sweep #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W)) u_sweep (
    .clk    (clk),
    .rst    (rst),
    .start  (sweep_start),
    .active (sweep_active),
    .idx    (sweep_idx),
    .last   (sweep_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else begin
      if (sweep_active) valid_q[sweep_idx] <= 1'b0;
      if (fill_commit)  valid_q[acc_idx]   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      tag_en_q  <= '1;
      acc_addr  <= '0;
      acc_we    <= 1'b0;
      acc_wdata <= '0;
      acc_en    <= '0;
      cpu_done  <= 1'b0;
      cpu_hit   <= 1'b0;
      cpu_rdata <= '0;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      mem_wr    <= 1'b0;
      mem_waddr <= '0;
      mem_wdata <= '0;
    end else begin
      cpu_done <= 1'b0;
      mem_wr   <= 1'b0;
      if (tag_en_wr) tag_en_q <= tag_en_din;
      case (st)
        ST_IDLE: begin
          if (inv_start) begin
            st <= ST_SWEEP;
          end else if (cpu_req) begin
            acc_addr  <= cpu_addr;
            acc_we    <= cpu_we;
            acc_wdata <= cpu_wdata;
            acc_en    <= tag_en_q;
            st        <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (acc_we) begin
            mem_wr    <= 1'b1;
            mem_waddr <= acc_addr;
            mem_wdata <= acc_wdata;
            cpu_done  <= 1'b1;
            cpu_hit   <= look_hit;
            st        <= ST_IDLE;
          end else if (look_hit) begin
            cpu_done  <= 1'b1;
            cpu_hit   <= 1'b1;
            cpu_rdata <= look_word;
            st        <= ST_IDLE;
          end else begin
            mem_req  <= 1'b1;
            mem_addr <= acc_addr[ADDR_W-1 -: LINE_ADDR_W];
            st       <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_done  <= 1'b1;
            cpu_hit   <= 1'b0;
            cpu_rdata <= fill_word;
            st        <= ST_IDLE;
          end
        end
        ST_SWEEP: begin
          if (sweep_last) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/narrow_tag_dcache_checker.sv
module narrow_tag_dcache_checker #(
  parameter int TAG_W       = 6,
  parameter int NUM_LINES   = 64,
  parameter int LINE_ADDR_W = 12
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cpu_done,
  input logic                   cpu_hit,
  input logic                   inv_start,
  input logic                   busy,
  input logic                   mem_req,
  input logic                   mem_ack,
  input logic [LINE_ADDR_W-1:0] mem_addr,
  input logic                   sweep_active,
  input logic                   in_look,
  input logic                   tag_re,
  input logic [TAG_W-1:0]       acc_en
);
  int sweep_run;

  always_ff @(posedge clk) begin
    if (rst) sweep_run <= 0;
    else     sweep_run <= sweep_active ? sweep_run + 1 : 0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    cpu_done |=> !cpu_done); // R11

  AST_REFILL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R8

  AST_HIT_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (cpu_done && cpu_hit) |-> !mem_req); // R5

  AST_ZERO_NO_TAG_READ: assert property (@(posedge clk) disable iff (rst)
    (in_look && (acc_en == '0)) |-> !$past(tag_re)); // R5

  AST_SWEEP_STARTS: assert property (@(posedge clk) disable iff (rst)
    (inv_start && !busy) |=> busy); // R6

  AST_SWEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
    sweep_active |-> !mem_req); // R6

  AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (rst)
    sweep_run <= NUM_LINES); // R6
endmodule

bind narrow_tag_dcache narrow_tag_dcache_checker #(
  .TAG_W(TAG_W), .NUM_LINES(NUM_LINES), .LINE_ADDR_W(LINE_ADDR_W)
) u_checker (
  .clk          (clk),
  .rst          (rst),
  .cpu_done     (cpu_done),
  .cpu_hit      (cpu_hit),
  .inv_start    (inv_start),
  .busy         (busy),
  .mem_req      (mem_req),
  .mem_ack      (mem_ack),
  .mem_addr     (mem_addr),
  .sweep_active (sweep_active),
  .in_look      (in_look),
  .tag_re       (tag_re),
  .acc_en       (acc_en)
);

// File: tb/narrow_tag_dcache_bench.sv
`timescale 1ns/1ps
module narrow_tag_dcache_bench;
  localparam int TAG_W = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_req = 1'b0, cpu_we = 1'b0;
  logic [15:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic         cpu_done, cpu_hit;
  logic [31:0]  cpu_rdata;
  logic         tag_en_wr = 1'b0;
  logic [5:0]   tag_en_din = '0;
  logic         inv_start = 1'b0;
  logic         busy;
  logic         mem_req;
  logic [11:0]  mem_addr;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;
  logic         mem_wr;
  logic [15:0]  mem_waddr;
  logic [31:0]  mem_wdata;

  int n_vec = 0;
  int n_bad = 0;
  bit finished = 0;

  // results of the last access
  logic        r_done, r_hit, r_mem, r_wr;
  logic [31:0] r_rd, r_wdata;
  logic [15:0] r_waddr;
  logic [11:0] r_mline;
  int          r_lat;

  always #2.5 clk = ~clk;

  narrow_tag_dcache u_narrow_tag_dcache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_done(cpu_done), .cpu_hit(cpu_hit), .cpu_rdata(cpu_rdata),
    .tag_en_wr(tag_en_wr), .tag_en_din(tag_en_din), .inv_start(inv_start), .busy(busy),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .mem_wr(mem_wr), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  function automatic logic [31:0] word_val(input logic [11:0] line, input int w);
    return 32'hC0DE_0000 ^ (32'(line) << 4) ^ 32'(w);
  endfunction

  function automatic logic [127:0] line_val(input logic [11:0] line);
    logic [127:0] v;
    for (int w = 0; w < 4; w++) v[w*32 +: 32] = word_val(line, w);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic set_en(input logic [5:0] v);
    @(negedge clk);
    tag_en_wr = 1'b1; tag_en_din = v;
    @(posedge clk); #1;
    tag_en_wr = 1'b0;
  endtask

  task automatic access(input logic we, input logic [15:0] a, input logic [31:0] wd,
                        input logic en_wr, input logic [5:0] en_v);
    bit acked;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    tag_en_wr = en_wr; tag_en_din = en_v;
    @(posedge clk); #1;
    cpu_req = 1'b0; tag_en_wr = 1'b0;
    r_done = 0; r_hit = 0; r_mem = 0; r_wr = 0; r_lat = 0; acked = 0;
    r_rd = '0; r_wdata = '0; r_waddr = '0; r_mline = '0;
    for (int k = 0; k < 30 && !r_done; k++) begin
      @(posedge clk); #1;
      r_lat++;
      if (mem_ack) mem_ack = 1'b0;
      if (cpu_done) begin
        r_done = 1; r_hit = cpu_hit; r_rd = cpu_rdata;
        r_wr = mem_wr; r_waddr = mem_waddr; r_wdata = mem_wdata;
      end else if (mem_req && !r_mem) begin
        r_mem = 1; r_mline = mem_addr;
      end else if (mem_req && !acked) begin
        mem_ack = 1'b1; mem_rdata = line_val(r_mline); acked = 1;
      end
    end
  endtask

  task automatic t_reset;
    chk(busy == 0 && cpu_done == 0 && mem_req == 0 && mem_wr == 0, "R2", "idle outputs after reset",
        {28'b0, busy, cpu_done, mem_req, mem_wr}, 32'h0);
    access(0, 16'h0040, 0, 0, 0);
    chk(r_done && !r_hit && r_mem, "R2", "first load misses", {31'b0, r_hit}, 32'h0);
    chk(r_mline == 12'h004, "R8", "refill line address", 32'(r_mline), 32'h004);
    chk(r_rd == word_val(12'h004, 0), "R8", "refill word", r_rd, word_val(12'h004, 0));
    chk(r_lat == 3, "R11", "miss done on ack edge", 32'(r_lat), 32'd3);
  endtask

  task automatic t_hit_path;
    access(0, 16'h0048, 0, 0, 0);
    chk(r_hit && !r_mem, "R1", "word 2 hit", {31'b0, r_hit}, 32'h1);
    chk(r_rd == word_val(12'h004, 2), "R1", "word 2 data", r_rd, word_val(12'h004, 2));
    chk(r_lat == 1, "R11", "hit latency", 32'(r_lat), 32'd1);
    access(0, 16'h004B, 0, 0, 0);
    chk(r_hit && r_rd == word_val(12'h004, 2), "R1", "byte bits ignored", r_rd, word_val(12'h004, 2));
  endtask

  task automatic t_full_conflict;
    access(0, 16'h8040, 0, 0, 0);
    chk(!r_hit && r_mem && r_rd == word_val(12'h804, 0), "R3", "tag msb conflict misses", r_rd, word_val(12'h804, 0));
    access(0, 16'h0040, 0, 0, 0);
    chk(!r_hit && r_mem, "R3", "evicted line misses again", {31'b0, r_hit}, 32'h0);
  endtask

  task automatic t_narrow;
    set_en(6'b000011);
    access(0, 16'h8044, 0, 0, 0);
    chk(r_hit && !r_mem, "R4", "disabled tag bit differs -> hit", {31'b0, r_hit}, 32'h1);
    chk(r_rd == word_val(12'h004, 1), "R4", "aliased data", r_rd, word_val(12'h004, 1));
    access(0, 16'h0444, 0, 0, 0);
    chk(!r_hit && r_mem && r_rd == word_val(12'h044, 1), "R4", "enabled tag bit differs -> miss", r_rd, word_val(12'h044, 1));
  endtask

  task automatic t_zero;
    set_en(6'b000000);
    access(0, 16'h7C44, 0, 0, 0);
    chk(r_hit && !r_mem && r_rd == word_val(12'h044, 1), "R5", "valid line hits any tag", r_rd, word_val(12'h044, 1));
    access(0, 16'h0090, 0, 0, 0);
    chk(!r_hit && r_mem && r_lat == 3, "R7", "untouched line misses", {31'b0, r_hit}, 32'h0);
    access(0, 16'h4090, 0, 0, 0);
    chk(r_hit && r_rd == word_val(12'h009, 0), "R7", "then hits for other tag", r_rd, word_val(12'h009, 0));
  endtask

  task automatic t_invalidate;
    int cnt;
    @(negedge clk);
    inv_start = 1'b1;
    @(posedge clk); #1;
    inv_start = 1'b0;
    cnt = 0;
    for (int k = 0; k < 200 && busy; k++) begin
      cnt++;
      @(posedge clk); #1;
    end
    chk(cnt == 64, "R6", "sweep busy cycles", 32'(cnt), 32'd64);
    access(0, 16'h7C44, 0, 0, 0);
    chk(!r_hit && r_mem && r_mline == 12'h7C4, "R6", "zero-mode load misses after sweep", 32'(r_mline), 32'h7C4);
  endtask

  task automatic t_store;
    set_en(6'b111111);
    access(0, 16'h0100, 0, 0, 0);
    chk(!r_hit && r_mem, "R9", "fill before store", {31'b0, r_hit}, 32'h0);
    access(1, 16'h0104, 32'h1234_5678, 0, 0);
    chk(r_hit && r_wr && r_lat == 1, "R9", "store hit writes through", {30'b0, r_hit, r_wr}, 32'h3);
    chk(r_waddr == 16'h0104 && r_wdata == 32'h1234_5678, "R9", "write-through data", r_wdata, 32'h1234_5678);
    access(0, 16'h0104, 0, 0, 0);
    chk(r_hit && r_rd == 32'h1234_5678, "R9", "stored word read back", r_rd, 32'h1234_5678);
    access(1, 16'h2200, 32'hDEAD_BEEF, 0, 0);
    chk(!r_hit && r_wr && !r_mem && r_wdata == 32'hDEAD_BEEF, "R9", "store miss writes through", r_wdata, 32'hDEAD_BEEF);
    access(0, 16'h2200, 0, 0, 0);
    chk(!r_hit && r_mem, "R9", "store miss did not allocate", {31'b0, r_hit}, 32'h0);
  endtask

  task automatic t_late_cfg;
    access(0, 16'h8100, 0, 1, 6'b000000);
    chk(!r_hit && r_mem, "R10", "mask write on accept edge ignored", {31'b0, r_hit}, 32'h0);
    access(0, 16'h4104, 0, 0, 0);
    chk(r_hit && r_rd == word_val(12'h810, 1), "R10", "new mask applies next access", r_rd, word_val(12'h810, 1));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_hit_path();
    t_full_conflict();
    t_narrow();
    t_zero();
    t_invalidate();
    t_store();
    t_late_cfg();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'h0, 32'h1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule